// File: doc/BRIEF.md
# Programmable Product-Term AND Array

This block forms eight product terms for one logic channel out of sixteen conditioned input signals. Each input of each term passes through a selectable treatment: force low, pass, invert or force high. The treated inputs of a term are ANDed into that term's output. The data path is purely combinational, so an input change shows at the outputs in the same cycle.

Each term has one configuration word, written and read through a simple register port with separate write and read addresses. A separate activation register gates all eight outputs. The channel drives its terms only after a fixed 16-bit key has been written to that register. Any other value written there turns the channel off.

Top module: `pterm_array`

## Requirements
- R1: After reset every configuration word reads 0, the activation register reads 0, and all term outputs are 0.
- R2: A term with a field holding code 0 (force low) is 0, whatever its inputs are. Input i is controlled by bits [2i+1:2i] of the term's word.
- R3: Code 1 in a field passes that input unchanged into the term's AND.
- R4: Code 2 in a field inverts that input before the AND.
- R5: Code 3 in a field makes that input a don't-care. An active term whose fields all hold code 3 is 1.
- R6: Each term output is the AND of all sixteen treated inputs. Term j is configured at address j (0 to 7) and drives bit j of term_o.
- R7: The activation register is at address 8. Writing it with bits [15:0] equal to 0xF00D activates the channel, and bits above 15 are ignored. Writing it with any other low half deactivates the channel.
- R8: While the channel is inactive, all term outputs are 0, regardless of configuration and inputs.
- R9: A term address reads back exactly the last word written there. Address 8 reads 1 when the channel is active and 0 otherwise.
- R10: Writes to addresses 9 to 15 change no configuration word and leave the activation state unchanged. Reads from those addresses return 0.
- R11: A write to one term's address leaves every other term's word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sig_i | input | 16 | Conditioned input signals |
| reg_we_i | input | 1 | Register write strobe |
| reg_waddr_i | input | 4 | Write address |
| reg_wdata_i | input | 32 | Write data |
| reg_raddr_i | input | 4 | Read address |
| reg_rdata_o | output | 32 | Read data, combinational from the read address |
| term_o | output | 8 | Gated product-term outputs |

## Verification
The assertions check several behaviours on every cycle. They check that an inactive channel holds every term low and that a force-low field always kills its term. They check that an active all-don't-care term is high. They check that the activation state changes only on a write to its address and follows the key comparison. They also check that a just-written word reads back and that unmapped reads return zero. Other behaviours can only be shown by the bench's scenarios. These are the per-position effect of pass and invert, which depends on the input value, and the isolation between terms. They also include the ignored upper key bits and the sweep of every code over every input position. The bench's model compares all terms and the read data each cycle to catch a wrong field slice or a wrong term index.

// File: rtl/pterm_pkg.sv
package pterm_pkg;

  typedef enum logic [1:0] {
    OP_ZERO = 2'd0,
    OP_PASS = 2'd1,
    OP_INV  = 2'd2,
    OP_ONE  = 2'd3
  } op_e;

  function automatic logic treat(input op_e op, input logic s);
    logic r;
    unique case (op)
      OP_ZERO: r = 1'b0;
      OP_PASS: r = s;
      OP_INV:  r = ~s;
      default: r = 1'b1;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/pterm_cfg_bank.sv
module pterm_cfg_bank #(
  parameter int TERMS  = 8,
  parameter int WORD_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [ADDR_W-1:0]       waddr_i,
  input  logic [WORD_W-1:0]       wdata_i,
  input  logic [ADDR_W-1:0]       raddr_i,
  output logic [TERMS*WORD_W-1:0] cfg_o,
  output logic [WORD_W-1:0]       rdata_o
);

  logic [WORD_W-1:0] word_q [TERMS];

  for (genvar j = 0; j < TERMS; j++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        word_q[j] <= '0;
      else if (we_i && waddr_i == ADDR_W'(j))
        word_q[j] <= wdata_i;
    end
    assign cfg_o[j*WORD_W +: WORD_W] = word_q[j];
  end

  // unmatched addresses read zero
  always_comb begin
    rdata_o = '0;
    for (int j = 0; j < TERMS; j++)
      if (raddr_i == ADDR_W'(j)) rdata_o = word_q[j];
  end

endmodule

// File: rtl/pterm_key_gate.sv
module pterm_key_gate #(
  parameter int               ADDR_W   = 4,
  parameter int               KEY_ADDR = 8,
  parameter int               KEY_W    = 16,
  parameter logic [KEY_W-1:0] KEY_VAL  = 16'hF00D
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [KEY_W-1:0]  key_i,
  output logic              active_o
);

  logic active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      active_q <= 1'b0;
    else if (we_i && waddr_i == ADDR_W'(KEY_ADDR))
      active_q <= (key_i == KEY_VAL);
  end

  assign active_o = active_q;

endmodule

// File: rtl/pterm_product.sv
module pterm_product import pterm_pkg::*; #(
  parameter int INPUTS = 16
) (
  input  logic [INPUTS-1:0]   sig_i,
  input  logic [2*INPUTS-1:0] sel_i,
  output logic                hit_o
);

  logic [INPUTS-1:0] lit;

  for (genvar i = 0; i < INPUTS; i++) begin : g_lit
    assign lit[i] = treat(op_e'(sel_i[2*i +: 2]), sig_i[i]);
  end

  assign hit_o = &lit;

endmodule

// File: rtl/pterm_array.sv
module pterm_array #(
  parameter int               INPUTS  = 16,
  parameter int               TERMS   = 8,
  parameter int               KEY_W   = 16,
  parameter logic [KEY_W-1:0] KEY_VAL = 16'hF00D,
  localparam int              WORD_W  = 2*INPUTS,
  localparam int              ADDR_W  = $clog2(TERMS+1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [INPUTS-1:0] sig_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_waddr_i,
  input  logic [WORD_W-1:0] reg_wdata_i,
  input  logic [ADDR_W-1:0] reg_raddr_i,
  output logic [WORD_W-1:0] reg_rdata_o,
  output logic [TERMS-1:0]  term_o
);

  localparam int KEY_ADDR = TERMS;

  logic [TERMS*WORD_W-1:0] cfg_words;
  logic [WORD_W-1:0]       bank_rdata;
  logic                    active_q;
  logic [TERMS-1:0]        raw_term;

  pterm_cfg_bank #(
    .TERMS (TERMS),
    .WORD_W(WORD_W),
    .ADDR_W(ADDR_W)
  ) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (reg_we_i),
    .waddr_i(reg_waddr_i),
    .wdata_i(reg_wdata_i),
    .raddr_i(reg_raddr_i),
    .cfg_o  (cfg_words),
    .rdata_o(bank_rdata)
  );

  pterm_key_gate #(
    .ADDR_W  (ADDR_W),
    .KEY_ADDR(KEY_ADDR),
    .KEY_W   (KEY_W),
    .KEY_VAL (KEY_VAL)
  ) u_key (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .waddr_i (reg_waddr_i),
    .key_i   (reg_wdata_i[KEY_W-1:0]),
    .active_o(active_q)
  );

  for (genvar j = 0; j < TERMS; j++) begin : g_term
    pterm_product #(.INPUTS(INPUTS)) u_prod (
      .sig_i(sig_i),
      .sel_i(cfg_words[j*WORD_W +: WORD_W]),
      .hit_o(raw_term[j])
    );
  end

  assign term_o = active_q ? raw_term : '0;

  always_comb begin
    if (reg_raddr_i == ADDR_W'(KEY_ADDR))
      reg_rdata_o = WORD_W'(active_q);
    else
      reg_rdata_o = bank_rdata;
  end

endmodule

// File: rtl/pterm_array_chk.sv
module pterm_array_chk #(
  parameter int               INPUTS  = 16,
  parameter int               TERMS   = 8,
  parameter int               KEY_W   = 16,
  parameter logic [KEY_W-1:0] KEY_VAL = 16'hF00D,
  localparam int              WORD_W  = 2*INPUTS,
  localparam int              ADDR_W  = $clog2(TERMS+1)
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    we_i,
  input logic [ADDR_W-1:0]       waddr_i,
  input logic [WORD_W-1:0]       wdata_i,
  input logic [ADDR_W-1:0]       raddr_i,
  input logic [WORD_W-1:0]       rdata_i,
  input logic [TERMS*WORD_W-1:0] cfg_i,
  input logic                    active_i,
  input logic [TERMS-1:0]        term_i
);

  localparam int KEY_ADDR = TERMS;

  logic              prev_hit;
  logic [ADDR_W-1:0] prev_addr;
  logic [WORD_W-1:0] prev_data;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_hit  <= 1'b0;
      prev_addr <= '0;
      prev_data <= '0;
    end else begin
      prev_hit  <= we_i && (waddr_i < ADDR_W'(TERMS));
      prev_addr <= waddr_i;
      prev_data <= wdata_i;
    end
  end

  logic key_wr;
  assign key_wr = we_i && (waddr_i == ADDR_W'(KEY_ADDR));

  assert_inactive_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |-> (term_i == '0));

  assert_key_match_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_wr && wdata_i[KEY_W-1:0] == KEY_VAL) |=> active_i);

  assert_key_miss_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_wr && wdata_i[KEY_W-1:0] != KEY_VAL) |=> !active_i);

  assert_key_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !key_wr |=> $stable(active_i));

  assert_readback_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prev_hit && raddr_i == prev_addr) |-> (rdata_i == prev_data));

  assert_unmapped_read_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raddr_i > ADDR_W'(KEY_ADDR)) |-> (rdata_i == '0));

  for (genvar j = 0; j < TERMS; j++) begin : g_chk
    logic any_zero, all_one;
    always_comb begin
      any_zero = 1'b0;
      all_one  = 1'b1;
      for (int i = 0; i < INPUTS; i++) begin
        if (cfg_i[j*WORD_W + 2*i +: 2] == 2'd0) any_zero = 1'b1;
        if (cfg_i[j*WORD_W + 2*i +: 2] != 2'd3) all_one  = 1'b0;
      end
    end

    assert_force_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      any_zero |-> !term_i[j]);

    assert_dont_care_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (active_i && all_one) |-> term_i[j]);
  end

endmodule

bind pterm_array pterm_array_chk #(
  .INPUTS (INPUTS),
  .TERMS  (TERMS),
  .KEY_W  (KEY_W),
  .KEY_VAL(KEY_VAL)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .we_i    (reg_we_i),
  .waddr_i (reg_waddr_i),
  .wdata_i (reg_wdata_i),
  .raddr_i (reg_raddr_i),
  .rdata_i (reg_rdata_o),
  .cfg_i   (cfg_words),
  .active_i(active_q),
  .term_i  (term_o)
);

// File: tb/pterm_array_bench.sv
`timescale 1ns/1ps
module pterm_array_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] sig = '0;
  logic        we = 1'b0;
  logic [3:0]  waddr = '0;
  logic [31:0] wdata = '0;
  logic [3:0]  raddr = '0;
  logic [31:0] rdata;
  logic [7:0]  term;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pterm_array u_pterm_array (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .sig_i      (sig),
    .reg_we_i   (we),
    .reg_waddr_i(waddr),
    .reg_wdata_i(wdata),
    .reg_raddr_i(raddr),
    .reg_rdata_o(rdata),
    .term_o     (term)
  );

  // reference model
  logic [31:0] m_cfg [8];
  bit          m_act;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < 8; j++) m_cfg[j] <= '0;
      m_act <= 1'b0;
    end else if (we) begin
      if (waddr < 8) m_cfg[waddr] <= wdata;
      else if (waddr == 8) m_act <= (wdata[15:0] == 16'hF00D);
    end
  end

  function automatic logic exp_term(input logic [31:0] w, input logic [15:0] s);
    logic r = 1'b1;
    for (int i = 0; i < 16; i++) begin
      case (w[2*i +: 2])
        2'd0: r = 1'b0;
        2'd1: r = r & s[i];
        2'd2: r = r & ~s[i];
        default: ;
      endcase
    end
    return r;
  endfunction

  function automatic logic [7:0] exp_terms();
    logic [7:0] v = '0;
    for (int j = 0; j < 8; j++) v[j] = m_act && exp_term(m_cfg[j], sig);
    return v;
  endfunction

  function automatic logic [31:0] exp_read(input logic [3:0] a);
    if (a < 8) return m_cfg[a];
    if (a == 8) return {31'b0, m_act};
    return '0;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the edge
  always @(posedge clk) begin
    #3;
    if (rst_n && !done) begin
      check(term === exp_terms(), "R6", {24'b0, term}, {24'b0, exp_terms()});
      check(rdata === exp_read(raddr), "R9", rdata, exp_read(raddr));
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; waddr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    raddr = a;
    #1;
    d = rdata;
  endtask

  logic [31:0] rv;

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(term === 8'h00, "R1", {24'b0, term}, 0);
    for (int a = 0; a <= 8; a++) begin
      rd(4'(a), rv);
      check(rv === 32'h0, "R1", rv, 0);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R8: inactive with don't-care word still low
    wr(4'd1, 32'hFFFF_FFFF);
    sig = 16'hA5A5; #1;
    check(term === 8'h00, "R8", {24'b0, term}, 0);

    // R7: correct key
    wr(4'd8, 32'h0000_F00D);
    rd(4'd8, rv);
    check(rv === 32'h1, "R7", rv, 1);
    #1;
    check(term === 8'h02, "R5", {24'b0, term}, 32'h02);

    // every code on every input position, term 0
    for (int p = 0; p < 16; p++) begin
      for (int c = 0; c < 4; c++) begin
        logic [31:0] w;
        w = 32'hFFFF_FFFF;
        w[2*p +: 2] = 2'(c);
        wr(4'd0, w);
        for (int v = 0; v < 2; v++) begin
          logic e;
          sig = 16'h0;
          sig[p] = 1'(v);
          #1;
          e = (c == 0) ? 1'b0 : (c == 1) ? 1'(v) : (c == 2) ? ~1'(v) : 1'b1;
          case (c)
            0: check(term[0] === e, "R2", {31'b0, term[0]}, {31'b0, e});
            1: check(term[0] === e, "R3", {31'b0, term[0]}, {31'b0, e});
            2: check(term[0] === e, "R4", {31'b0, term[0]}, {31'b0, e});
            default: check(term[0] === e, "R5", {31'b0, term[0]}, {31'b0, e});
          endcase
        end
      end
    end

    // R6: all-pass term needs all ones
    wr(4'd3, 32'h5555_5555);
    sig = 16'hFFFF; #1;
    check(term[3] === 1'b1, "R6", {31'b0, term[3]}, 1);
    sig = 16'hFFFE; #1;
    check(term[3] === 1'b0, "R6", {31'b0, term[3]}, 0);
    // mixed pass/invert: inputs 0..7 pass, 8..15 invert
    wr(4'd7, 32'hAAAA_5555);
    sig = 16'h00FF; #1;
    check(term[7] === 1'b1, "R6", {31'b0, term[7]}, 1);
    sig = 16'h01FF; #1;
    check(term[7] === 1'b0, "R6", {31'b0, term[7]}, 0);

    // R9 / R11: readback and isolation
    wr(4'd4, 32'h1234_5678);
    wr(4'd5, 32'h9ABC_DEF0);
    rd(4'd4, rv);
    check(rv === 32'h1234_5678, "R11", rv, 32'h1234_5678);
    rd(4'd5, rv);
    check(rv === 32'h9ABC_DEF0, "R9", rv, 32'h9ABC_DEF0);

    // R10: unmapped writes and reads
    wr(4'd12, 32'hDEAD_F00D);
    wr(4'd9, 32'h0000_0000);
    for (int a = 9; a < 16; a++) begin
      rd(4'(a), rv);
      check(rv === 32'h0, "R10", rv, 0);
    end
    rd(4'd8, rv);
    check(rv === 32'h1, "R10", rv, 1);
    rd(4'd4, rv);
    check(rv === 32'h1234_5678, "R10", rv, 32'h1234_5678);

    // R7: wrong keys deactivate
    wr(4'd8, 32'h0000_F00C);
    rd(4'd8, rv);
    check(rv === 32'h0, "R7", rv, 0);
    sig = 16'hFFFF; #1;
    check(term === 8'h00, "R8", {24'b0, term}, 0);
    wr(4'd8, 32'hABCD_F00D);
    rd(4'd8, rv);
    check(rv === 32'h1, "R7", rv, 1);
    wr(4'd8, 32'h0000_D00F);
    rd(4'd8, rv);
    check(rv === 32'h0, "R7", rv, 0);
    wr(4'd8, 32'h0000_F00D);
    wr(4'd8, 32'h0);
    rd(4'd8, rv);
    check(rv === 32'h0, "R7", rv, 0);
    wr(4'd8, 32'h0000_F00D);

    // random traffic compared by the model
    for (int k = 0; k < 300; k++) begin
      logic [31:0] w;
      for (int i = 0; i < 16; i++) w[2*i +: 2] = 2'(1 + ($urandom % 3));
      @(negedge clk);
      sig = 16'($urandom);
      raddr = 4'($urandom);
      if (($urandom % 4) == 0) begin
        we = 1'b1;
        waddr = 4'($urandom % 8);
        wdata = w;
      end else begin
        we = 1'b0;
      end
    end
    @(negedge clk);
    we = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule